// File: doc/BRIEF.md
# Serial Peripheral Master with Data-Ready Gating

This block is a serial peripheral master for word transfers of 1 to 16 bits. Software sets it up and starts it through one 16-bit control word. Words to send are pushed into an 8-entry transmit queue. Words shifted in from the slave land in an 8-entry receive queue, where software pops them. The block drives the serial clock, the outgoing data line and the slave select, and it samples the incoming data line. The serial clock is the system clock divided by a power of two between 4 and 512. Clock polarity and clock phase are both selectable.

Software starts an exchange by writing the control word with the start bit set. The start bit then reads back as 1 while the block waits and while it shifts. It clears by itself once the transmit queue is empty and the last word has finished. The exchange can be held back by an external data-ready input (active low). The control word selects one of three ways to treat it: ignore it, wait for a falling edge that comes after the start, or wait for a low level. Clearing the enable bit empties both queues and stops any exchange that is running.

The sequencer has five states. In IDLE the select is inactive and the clock rests at its idle level. WAIT_RDY holds a started exchange until the data-ready rule is met. LOAD takes the next word from the transmit queue. SHIFT produces two clock edges for each bit. FINISH stores the received word. The transitions are:

- IDLE to WAIT_RDY on an accepted start.
- WAIT_RDY to LOAD when the data-ready rule is met.
- LOAD to SHIFT when a word is present, or LOAD to IDLE when the queue is empty.
- SHIFT to FINISH on the last clock edge.
- FINISH to LOAD when more words are queued, or FINISH to IDLE otherwise.
- Any state to IDLE when the enable bit is written as 0.

Top module: `spi_drdy_master`

## Requirements
- R1: After reset the control word reads 0x0000, the serial clock is low, the select is high (inactive for polarity 0), the transmit queue is not full and the receive queue is empty.
- R2: Bits 15:13 hold the rate code n. Each half period of the serial clock lasts 2<<n system clock cycles, so the full period is 4<<n cycles.
- R3: Writing the control word with bit 8 = 1, bit 9 (enable) = 1 and bit 10 (master) = 1 starts an exchange. Bit 8 reads 1 from the next cycle until the transmit queue is empty and the last word has finished, and then it reads 0.
- R4: A start request is ignored when the written enable bit or the written master bit is 0. Bit 8 stays 0 and no word is shifted.
- R5: Bits 3:0 hold L, and the word length is L+1 bits. Words are sent MSB first, from bit L of the queued word down to bit 0. The received word sits in bits L:0 of the receive entry, and all higher bits are 0.
- R6: Bit 4 (clock polarity) sets the idle level of the serial clock. Bit 5 (phase) chooses the sampling edge: with phase 0 data is sampled on the first edge of each bit, and with phase 1 on the second edge.
- R7: Bit 7 sets the active level of the select: 0 means active low, 1 means active high. The select is active only while words are loaded and shifted, and inactive in IDLE and WAIT_RDY.
- R8: With bits 12:11 = 01, a started exchange waits until the synchronized data-ready input shows a falling edge after the start. A short low pulse is latched, so it is not lost.
- R9: With bits 12:11 = 10, a started exchange waits while data-ready is high and proceeds once it is low.
- R10: With bits 12:11 = 00 or 11, data-ready is ignored and the exchange proceeds at once.
- R11: Each queue holds 8 words. A push into a full transmit queue is dropped. A word received while the receive queue is full is discarded, and the stored entries stay as they were.
- R12: Writing the control word with bit 9 = 0 empties both queues, ends any exchange and returns the block to IDLE with bit 8 at 0.
- R13: Every written control bit except bit 8 reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write value |
| reg_rdata | output | 16 | Control word read value, with bit 8 showing busy |
| tx_push | input | 1 | Push tx_wdata into the transmit queue |
| tx_wdata | input | 16 | Word to transmit |
| tx_full | output | 1 | Transmit queue is full |
| rx_pop | input | 1 | Pop the head of the receive queue |
| rx_rdata | output | 16 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue is empty |
| rdy_n | input | 1 | External data-ready input, asynchronous, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel | output | 1 | Slave select |

## Verification
The hardest case to reach from the ports is a start that sits parked in WAIT_RDY. To reach it, the bench first holds data-ready high under the edge rule and the level rule. It then confirms that bit 8 reads 1 while the select and the clock stay idle, and only after that releases a short low pulse or a low level. A second case that is hard to reach is a received word arriving at a full receive queue. To get there, the bench first fills the receive queue through an exchange of eight words. It then runs one more exchange and checks the full sequence of popped words. A data loopback through an inverter, together with a bench-side capture on the sampling edge chosen by the polarity and phase bits, checks bit order and clock edges for each table row.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_RDY,
        ST_LOAD,
        ST_SHIFT,
        ST_FINISH
    } spim_state_e;

    // Field order follows the 16-bit control word, MSB first.
    typedef struct packed {
        logic [2:0] rate;
        logic [1:0] rdy_mode;
        logic       master;
        logic       enable;
        logic       start;
        logic       sel_pol;
        logic       sel_ctl;
        logic       cpha;
        logic       cpol;
        logic [3:0] len_m1;
    } spim_ctrl_t;

    localparam logic [1:0] RDY_IGNORE = 2'b00;
    localparam logic [1:0] RDY_FALL   = 2'b01;
    localparam logic [1:0] RDY_LOW    = 2'b10;

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               wdata,
    input  logic                       pop,
    output logic [W-1:0]               rdata,
    output logic                       full,
    output logic                       empty,
    output logic [$clog2(DEPTH):0]     count
);
    // DEPTH must be a power of two so the pointers wrap naturally.
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == (AW+1)'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wp] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                wp <= wp + 1'b1;
            end
            if (do_pop) begin
                rp <= rp + 1'b1;
            end
            count <= count + {{AW{1'b0}}, do_push} - {{AW{1'b0}}, do_pop};
        end
    end

endmodule

// File: rtl/spim_rdy_sync.sv
module spim_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_n_async,
    input  logic clr_fall,
    output logic rdy_low,
    output logic fall_seen
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;
    logic              synced;

    assign synced  = sync_q[STAGES-1];
    assign rdy_low = !synced;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q    <= '1;
            last_q    <= 1'b1;
            fall_seen <= 1'b0;
        end else begin
            sync_q    <= {sync_q[STAGES-2:0], rdy_n_async};
            last_q    <= synced;
            if (clr_fall) begin
                fall_seen <= 1'b0;
            end else if (last_q && !synced) begin
                fall_seen <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_drdy_master.sv
module spi_drdy_master
    import spim_pkg::*;
#(
    parameter int DW         = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_wdata,
    output logic          tx_full,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_rdata,
    output logic          rx_empty,
    input  logic          rdy_n,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          ssel
);
    localparam int CW  = $clog2(FIFO_DEPTH) + 1;
    localparam int ECW = $clog2(DW) + 1;
    localparam int DVW = 9;

    spim_state_e state, nstate;
    spim_ctrl_t  ctrl_q, wr_ctrl;

    logic [CW-1:0]  tx_cnt, rx_cnt;
    logic [DW-1:0]  tx_head, tx_sh, rx_sh;
    logic           tx_empty;
    logic [DVW-1:0] div_cnt, half_m1;
    logic [ECW-1:0] edge_cnt, last_edge;
    logic           sclk_q;
    logic           start_req, dis_req, rdy_ok, tick;
    logic           sample_edge, launch_edge;
    logic           tx_pop, rx_push, sel_act, rdy_low, fall_seen;

    assign wr_ctrl   = spim_ctrl_t'(reg_wdata);
    assign start_req = reg_wr && wr_ctrl.start && wr_ctrl.enable && wr_ctrl.master;
    assign dis_req   = reg_wr && !wr_ctrl.enable;

    // Control word storage; the start bit is never stored, it reads as busy.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr) begin
            ctrl_q       <= wr_ctrl;
            ctrl_q.start <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata    = ctrl_q;
        reg_rdata[8] = (state != ST_IDLE);
    end

    spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(dis_req),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty), .count(tx_cnt)
    );

    spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(dis_req),
        .push(rx_push), .wdata(rx_sh), .pop(rx_pop), .rdata(rx_rdata),
        .full(), .empty(rx_empty), .count(rx_cnt)
    );

    spim_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy (
        .clk(clk), .rst_n(rst_n), .rdy_n_async(rdy_n),
        .clr_fall(start_req), .rdy_low(rdy_low), .fall_seen(fall_seen)
    );

    always_comb begin
        unique case (ctrl_q.rdy_mode)
            RDY_FALL: rdy_ok = fall_seen;
            RDY_LOW:  rdy_ok = rdy_low;
            default:  rdy_ok = 1'b1;
        endcase
    end

    // Clock divider and edge bookkeeping.
    assign half_m1     = (DVW'(2) << ctrl_q.rate) - DVW'(1);
    assign tick        = (div_cnt == '0);
    assign last_edge   = ECW'({ctrl_q.len_m1, 1'b1});
    assign sample_edge = (edge_cnt[0] == ctrl_q.cpha);
    assign launch_edge = !sample_edge && (edge_cnt != '0) && (edge_cnt != last_edge);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nstate;
        end
    end

    // Next-state logic.
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:     if (start_req) nstate = ST_WAIT_RDY;
            ST_WAIT_RDY: if (rdy_ok) nstate = ST_LOAD;
            ST_LOAD:     nstate = tx_empty ? ST_IDLE : ST_SHIFT;
            ST_SHIFT:    if (tick && edge_cnt == last_edge) nstate = ST_FINISH;
            ST_FINISH:   nstate = tx_empty ? ST_IDLE : ST_LOAD;
            default:     nstate = ST_IDLE;
        endcase
        if (dis_req) begin
            nstate = ST_IDLE;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        tx_pop  = (state == ST_LOAD) && !tx_empty;
        rx_push = (state == ST_FINISH);
        sel_act = tx_pop || (state == ST_SHIFT) || (state == ST_FINISH);
        ssel    = sel_act ? ctrl_q.sel_pol : !ctrl_q.sel_pol;
        sclk    = sclk_q;
        mosi    = tx_sh[DW-1];
    end

    // Shift datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh    <= '0;
            rx_sh    <= '0;
            div_cnt  <= '0;
            edge_cnt <= '0;
            sclk_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_LOAD: begin
                    tx_sh    <= tx_head << (4'(DW-1) - ctrl_q.len_m1);
                    rx_sh    <= '0;
                    div_cnt  <= half_m1;
                    edge_cnt <= '0;
                    sclk_q   <= ctrl_q.cpol;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        div_cnt  <= half_m1;
                        sclk_q   <= !sclk_q;
                        edge_cnt <= edge_cnt + 1'b1;
                        if (sample_edge) begin
                            rx_sh <= {rx_sh[DW-2:0], miso};
                        end
                        if (launch_edge) begin
                            tx_sh <= tx_sh << 1;
                        end
                    end else begin
                        div_cnt <= div_cnt - 1'b1;
                    end
                end
                default: begin
                    sclk_q <= ctrl_q.cpol;
                end
            endcase
        end
    end

endmodule

// File: rtl/spim_checker.sv
module spim_checker
    import spim_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic        clk,
    input logic        rst_n,
    input spim_state_e state,
    input logic        cpol,
    input logic        sel_pol,
    input logic        sclk,
    input logic        ssel,
    input logic        reg_wr,
    input logic [15:0] reg_wdata,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt
);
    a_r7_sel_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_WAIT_RDY) |-> (ssel == !sel_pol));

    a_r6_sclk_rests: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE && $stable(cpol)) |-> (sclk == cpol));

    a_r4_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && reg_wr && !(reg_wdata[9] && reg_wdata[10])) |=> (state == ST_IDLE));

    a_r3_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && reg_wr && reg_wdata[10:8] == 3'b111) |=> (state == ST_WAIT_RDY));

    a_r12_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_wdata[9]) |=> (state == ST_IDLE && tx_cnt == '0 && rx_cnt == '0));

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

endmodule

bind spi_drdy_master spim_checker #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .cpol(ctrl_q.cpol),
    .sel_pol(ctrl_q.sel_pol), .sclk(sclk), .ssel(ssel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spi_drdy_master_tb.sv
module spi_drdy_master_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        tx_push = 1'b0;
    logic [15:0] tx_wdata = '0;
    logic        tx_full;
    logic        rx_pop = 1'b0;
    logic [15:0] rx_rdata;
    logic        rx_empty;
    logic        rdy_n = 1'b1;
    logic        sclk, mosi, miso, ssel;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #10ns clk = ~clk;

    assign miso = ~mosi;

    spi_drdy_master u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .tx_push(tx_push), .tx_wdata(tx_wdata),
        .tx_full(tx_full), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_empty(rx_empty), .rdy_n(rdy_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .ssel(ssel)
    );

    // Slave-side capture on the configured sampling edge.
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_spol = 1'b0;
    logic [15:0] s_cap = '0;
    always @(sclk) begin
        if (ssel == cfg_spol) begin
            if ((sclk != cfg_cpol) != cfg_cpha) begin
                s_cap = {s_cap[14:0], mosi};
            end
        end
    end

    // {rate, cpol, cpha, len_m1, data}
    localparam logic [24:0] VEC [6] = '{
        {3'd0, 1'b0, 1'b0, 4'd7,  16'h00A5},
        {3'd1, 1'b1, 1'b0, 4'd15, 16'hC3A1},
        {3'd2, 1'b0, 1'b1, 4'd0,  16'h0001},
        {3'd3, 1'b1, 1'b1, 4'd11, 16'h0ABC},
        {3'd7, 1'b0, 1'b1, 4'd3,  16'hFFF9},
        {3'd5, 1'b1, 1'b0, 4'd15, 16'h8001}
    };

    function automatic logic [15:0] mk(input logic [2:0] rate, input logic [1:0] rmode,
                                       input logic mst, input logic en, input logic st,
                                       input logic spol, input logic cpha, input logic cpol,
                                       input logic [3:0] lm1);
        return {rate, rmode, mst, en, st, spol, 1'b0, cpha, cpol, lm1};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic push(input logic [15:0] v);
        @(negedge clk);
        tx_push = 1'b1;
        tx_wdata = v;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (reg_rdata[8] && n < 40000) begin
            @(negedge clk);
            n++;
        end
        check(req, {31'd0, reg_rdata[8]}, 32'd0);
    endtask

    initial begin
        #(20ns * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] mask;
        int half;
        wait_cycles(3);
        // R1 reset state
        check("R1 rdata", reg_rdata, 32'h0);
        check("R1 sclk", sclk, 1'b0);
        check("R1 ssel", ssel, 1'b1);
        check("R1 tx_full", tx_full, 1'b0);
        check("R1 rx_empty", rx_empty, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        wait_cycles(2);

        // R13 readback, R6 idle level, R7 inactive level
        write_reg(16'hF4F5);
        check("R13 readback", reg_rdata, 32'hF4F5);
        wait_cycles(3);
        check("R6 idle cpol=1", sclk, 1'b1);
        check("R7 inactive pol=1", ssel, 1'b0);
        write_reg(16'h0000);
        wait_cycles(3);

        // Table walk: R2, R3, R5, R6, R7
        for (int v = 0; v < 6; v++) begin
            logic [2:0]  rate;
            logic        cp, ch;
            logic [3:0]  lm1;
            logic [15:0] d;
            {rate, cp, ch, lm1, d} = VEC[v];
            mask = 16'((17'd1 << (lm1 + 1)) - 1);
            cfg_cpol = cp; cfg_cpha = ch; cfg_spol = 1'b0;
            write_reg(mk(rate, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, ch, cp, lm1));
            wait_cycles(2);
            push(d);
            write_reg(mk(rate, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, ch, cp, lm1));
            check("R3 busy after start", reg_rdata[8], 1'b1);
            while (sclk == cp) @(negedge clk);
            check("R7 active during shift", ssel, 1'b0);
            half = 0;
            while (sclk != cp) begin
                @(negedge clk);
                half++;
            end
            check("R2 half period", half, 32'(2 << rate));
            wait_idle("R3 busy clears");
            check("R5 R6 wire bits", s_cap & mask, d & mask);
            check("R5 received word", rx_rdata, (~d) & mask);
            pop();
        end

        // R4 start ignored
        cfg_cpol = 1'b0; cfg_cpha = 1'b0;
        write_reg(mk(3'd0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3));
        push(16'h3);
        write_reg(mk(3'd0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3));
        check("R4 slave mode busy", reg_rdata[8], 1'b0);
        wait_cycles(100);
        check("R4 slave mode no rx", rx_empty, 1'b1);
        check("R4 slave mode select", ssel, 1'b1);
        write_reg(mk(3'd0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3));
        check("R4 disabled busy", reg_rdata[8], 1'b0);

        // R11 queue limits
        write_reg(mk(3'd0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3));
        for (int i = 0; i < 8; i++) push(16'(i + 1));
        check("R11 tx full", tx_full, 1'b1);
        push(16'h9);
        write_reg(mk(3'd0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3));
        wait_idle("R3 multiword done");
        check("R11 ninth push dropped", s_cap & 16'hF, 16'h8);
        push(16'hA);
        write_reg(mk(3'd0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3));
        wait_idle("R3 extra word done");
        check("R11 extra word sent", s_cap & 16'hF, 16'hA);
        for (int i = 0; i < 8; i++) begin
            check("R11 rx entry kept", rx_rdata, (~16'(i + 1)) & 16'hF);
            pop();
        end
        check("R11 full rx discarded", rx_empty, 1'b1);

        // R12 flush and abort
        push(16'h1); push(16'h2);
        write_reg(mk(3'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3));
        write_reg(mk(3'd0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3));
        wait_idle("R12 empty tx finishes");
        check("R12 tx flushed", rx_empty, 1'b1);
        push(16'h5);
        write_reg(mk(3'd0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3));
        wait_idle("R12 fill rx");
        check("R12 rx filled", rx_empty, 1'b0);
        write_reg(mk(3'd0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3));
        check("R12 rx flushed", rx_empty, 1'b1);
        write_reg(mk(3'd7, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd15));
        push(16'hFFFF);
        write_reg(mk(3'd7, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd15));
        wait_cycles(1000);
        check("R12 busy before abort", reg_rdata[8], 1'b1);
        write_reg(mk(3'd7, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd15));
        check("R12 abort busy", reg_rdata[8], 1'b0);
        check("R12 abort select", ssel, 1'b1);
        wait_cycles(2);
        check("R12 abort sclk idle", sclk, 1'b0);

        // R8 falling edge qualification
        write_reg(mk(3'd0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3));
        push(16'h5);
        write_reg(mk(3'd0, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3));
        wait_cycles(300);
        check("R8 waiting busy", reg_rdata[8], 1'b1);
        check("R8 waiting select", ssel, 1'b1);
        check("R8 waiting sclk", sclk, 1'b0);
        rdy_n = 1'b0;
        wait_cycles(2);
        rdy_n = 1'b1;
        wait_idle("R8 done after edge");
        check("R8 rx word", rx_rdata, 16'hA);
        pop();

        // R9 low level qualification
        write_reg(mk(3'd0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3));
        push(16'h6);
        write_reg(mk(3'd0, 2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3));
        wait_cycles(300);
        check("R9 waiting busy", reg_rdata[8], 1'b1);
        check("R9 waiting rx", rx_empty, 1'b1);
        rdy_n = 1'b0;
        wait_idle("R9 done on low");
        check("R9 rx word", rx_rdata, 16'h9);
        pop();
        rdy_n = 1'b1;

        // R10 ignored input, codes 00 and 11
        for (int m = 0; m < 2; m++) begin
            logic [1:0] rm;
            rm = (m == 0) ? 2'b00 : 2'b11;
            write_reg(mk(3'd0, rm, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3));
            push(16'h3);
            write_reg(mk(3'd0, rm, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd3));
            wait_cycles(200);
            check("R10 no wait busy", reg_rdata[8], 1'b0);
            check("R10 rx word", rx_rdata, 16'hC);
            pop();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule